// File: doc/BRIEF.md
# Startup Calibration Sequencer

This block steps a pulse-induction receive chain from power-on, or from any change to its timing settings, up to steady measurement. It passes through five phases in a fixed order. First it waits while event timings and decimation rates settle. Next it trims the damping start point against the S0 sample. It then records a coil-only decay baseline for samples S1 to S3, followed by a ground-plus-coil baseline for the same three samples. Finally it enters normal operation.

The receive filters mark each new output word with a single-cycle ready pulse. The sequencer counts those pulses to decide when each phase has settled. In normal operation it turns every ready pulse into three normalized target-strength words, together with a one-cycle valid strobe that tells the host fresh data is available. A timing-change pulse sends the sequence back to the start from any phase.

Top module: `calib_sequencer`

## Requirements
- R1: While `rstN` is low, and in the cycle after it rises, `phase` reads 0 (CALC), `normValid` is 0, and every baseline and normalized output is 0.
- R2: `phase` uses the encoding CALC=0, TRIM=1, COIL=2, GND=3, RUN=4. It only ever moves to the next value in that order, or back to 0.
- R3: In CALC, COIL and GND, the phase advances on the clock edge that samples the `settleCount`-th ready pulse counted since the phase was entered. A `settleCount` of 0 behaves like 1.
- R4: While in CALC, `dampTrim` takes the value of `dampInit` one clock later.
- R5: In TRIM, a ready pulse with `s0In` inside the inclusive signed window [`winLo`, `winHi`] moves the phase to COIL and leaves `dampTrim` unchanged.
- R6: In TRIM, a ready pulse with `s0In` above `winHi` raises `dampTrim` by 1, and one with `s0In` below `winLo` lowers it by 1. The value holds at 0 and at its all-ones maximum.
- R7: In TRIM, the `maxIter`-th out-of-window pulse applies its step and moves the phase to COIL.
- R8: The ready pulse that ends COIL loads `s1In`..`s3In` into `coilBase1`..`3`. The pulse that ends GND loads them into `gndBase1`..`3`. The baselines hold their values at all other times.
- R9: In RUN, each ready pulse makes `normK` = `sK` − `gndBaseK`, saturated to the signed `DATA_W` range, and raises `normValid` for exactly one cycle. Both become visible one clock after the pulse is sampled.
- R10: `normValid` stays 0 for ready pulses seen outside RUN.
- R11: A `timingChange` pulse in any phase makes `phase` read CALC one clock later. It takes priority over a ready pulse arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timingChange | input | 1 | Restart pulse sent when timing parameters change |
| rdyPulse | input | 1 | Filter data-ready pulse |
| settleCount | input | CNT_W | Ready pulses per settling phase |
| maxIter | input | ITER_W | Trim iteration limit |
| dampInit | input | TRIM_W | Starting damp trim value |
| winLo | input | DATA_W | Lower bound of the S0 window, signed |
| winHi | input | DATA_W | Upper bound of the S0 window, signed |
| s0In | input | DATA_W | S0 filtered sample, signed |
| s1In | input | DATA_W | S1 filtered sample, signed |
| s2In | input | DATA_W | S2 filtered sample, signed |
| s3In | input | DATA_W | S3 filtered sample, signed |
| phase | output | 3 | Current phase code |
| dampTrim | output | TRIM_W | Damp start trim |
| coilBase1 | output | DATA_W | Coil-only baseline, S1 |
| coilBase2 | output | DATA_W | Coil-only baseline, S2 |
| coilBase3 | output | DATA_W | Coil-only baseline, S3 |
| gndBase1 | output | DATA_W | Ground-plus-coil baseline, S1 |
| gndBase2 | output | DATA_W | Ground-plus-coil baseline, S2 |
| gndBase3 | output | DATA_W | Ground-plus-coil baseline, S3 |
| norm1 | output | DATA_W | Normalized S1 |
| norm2 | output | DATA_W | Normalized S2 |
| norm3 | output | DATA_W | Normalized S3 |
| normValid | output | 1 | One-cycle strobe marking new normalized data |

## Verification
Every result here sits exactly one register after the edge that samples its cause. Phase moves, trim steps, baseline loads, the normalized words, `normValid` and the return to CALC after `timingChange` all appear on the edge that follows the ready or restart pulse. The one exception is the `dampInit` load, which needs a clock spent in CALC. The bench drives inputs on falling edges and reads outputs just after the next falling edge, so each read lands in the single cycle where the result is due. For `normValid` it also reads one cycle later to confirm the strobe has dropped again.

// File: rtl/calib_pkg.sv
package calib_pkg;

  localparam int NUM_SAMP = 3;

  typedef enum logic [2:0] {
    PH_CALC = 3'd0,
    PH_TRIM = 3'd1,
    PH_COIL = 3'd2,
    PH_GND  = 3'd3,
    PH_RUN  = 3'd4
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capCoil;
    logic capGnd;
    logic doNorm;
  } strobe_t;

endpackage

// File: rtl/calib_ctrl.sv
module calib_ctrl
  import calib_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int ITER_W = 8,
  parameter int TRIM_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     timingChange,
  input  logic                     rdyPulse,
  input  logic [CNT_W-1:0]         settleCount,
  input  logic [ITER_W-1:0]        maxIter,
  input  logic [TRIM_W-1:0]        dampInit,
  input  logic signed [DATA_W-1:0] winLo,
  input  logic signed [DATA_W-1:0] winHi,
  input  logic signed [DATA_W-1:0] s0In,
  output phase_e                   stateQ,
  output logic [TRIM_W-1:0]        trimQ,
  output strobe_t                  str
);

  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};

  logic [CNT_W-1:0]  cntQ;
  logic [ITER_W-1:0] iterQ;
  logic [CNT_W:0]    cntNext;
  logic [ITER_W:0]   iterNext;
  logic              settled;
  logic              lastIter;
  logic              inWin;
  logic              tooHigh;
  logic              tooLow;

  assign cntNext  = {1'b0, cntQ} + 1'b1;
  assign iterNext = {1'b0, iterQ} + 1'b1;
  assign settled  = cntNext >= {1'b0, settleCount};
  assign lastIter = iterNext >= {1'b0, maxIter};
  assign tooHigh  = s0In > winHi;
  assign tooLow   = s0In < winLo;
  assign inWin    = !tooHigh && !tooLow;

  always_comb begin
    str         = '0;
    str.capCoil = (stateQ == PH_COIL) && rdyPulse && settled && !timingChange;
    str.capGnd  = (stateQ == PH_GND)  && rdyPulse && settled && !timingChange;
    str.doNorm  = (stateQ == PH_RUN)  && rdyPulse && !timingChange;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= PH_CALC;
      cntQ   <= '0;
      iterQ  <= '0;
      trimQ  <= '0;
    end else if (timingChange) begin
      stateQ <= PH_CALC;
      cntQ   <= '0;
      iterQ  <= '0;
    end else begin
      unique case (stateQ)
        PH_CALC: begin
          trimQ <= dampInit;
          if (rdyPulse) begin
            if (settled) begin
              stateQ <= PH_TRIM;
              cntQ   <= '0;
              iterQ  <= '0;
            end else begin
              cntQ <= cntNext[CNT_W-1:0];
            end
          end
        end
        PH_TRIM: begin
          if (rdyPulse) begin
            if (inWin) begin
              stateQ <= PH_COIL;
              cntQ   <= '0;
            end else begin
              if (tooHigh && trimQ != TRIM_MAX) trimQ <= trimQ + 1'b1;
              if (tooLow  && trimQ != '0)       trimQ <= trimQ - 1'b1;
              if (lastIter) begin
                stateQ <= PH_COIL;
                cntQ   <= '0;
              end else begin
                iterQ <= iterNext[ITER_W-1:0];
              end
            end
          end
        end
        PH_COIL, PH_GND: begin
          if (rdyPulse) begin
            if (settled) begin
              stateQ <= (stateQ == PH_COIL) ? PH_GND : PH_RUN;
              cntQ   <= '0;
            end else begin
              cntQ <= cntNext[CNT_W-1:0];
            end
          end
        end
        default: ;
      endcase
    end
  end

  p_phase_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != $past(stateQ)) |->
      (stateQ == PH_CALC || 3'(stateQ) == 3'($past(stateQ)) + 3'd1));

  p_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
    timingChange |=> (stateQ == PH_CALC));

  p_in_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PH_TRIM && rdyPulse && !timingChange && inWin) |=>
      (stateQ == PH_COIL && $stable(trimQ)));

  p_trim_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateQ) != PH_CALC) |->
      (trimQ == $past(trimQ) || trimQ == $past(trimQ) + 1'b1 ||
       trimQ == $past(trimQ) - 1'b1));

endmodule

// File: rtl/calib_datapath.sv
module calib_datapath
  import calib_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  str,
  input  logic signed [DATA_W-1:0] sampIn  [NUM_SAMP],
  output logic signed [DATA_W-1:0] coilQ   [NUM_SAMP],
  output logic signed [DATA_W-1:0] gndQ    [NUM_SAMP],
  output logic signed [DATA_W-1:0] normQ   [NUM_SAMP],
  output logic                     normValidQ
);

  localparam logic signed [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

  for (genvar k = 0; k < NUM_SAMP; k++) begin : g_ch
    logic signed [DATA_W:0]   diff;
    logic signed [DATA_W-1:0] sat;

    assign diff = {sampIn[k][DATA_W-1], sampIn[k]} - {gndQ[k][DATA_W-1], gndQ[k]};

    always_comb begin
      if (diff[DATA_W] != diff[DATA_W-1]) sat = diff[DATA_W] ? SMIN : SMAX;
      else                                sat = diff[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        coilQ[k] <= '0;
        gndQ[k]  <= '0;
        normQ[k] <= '0;
      end else begin
        if (str.capCoil) coilQ[k] <= sampIn[k];
        if (str.capGnd)  gndQ[k]  <= sampIn[k];
        if (str.doNorm)  normQ[k] <= sat;
      end
    end

    p_coil_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      !str.capCoil |=> $stable(coilQ[k]));

    p_gnd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      !str.capGnd |=> $stable(gndQ[k]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) normValidQ <= 1'b0;
    else       normValidQ <= str.doNorm;
  end

endmodule

// File: rtl/calib_sequencer.sv
module calib_sequencer
  import calib_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int ITER_W = 8,
  parameter int TRIM_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     timingChange,
  input  logic                     rdyPulse,
  input  logic [CNT_W-1:0]         settleCount,
  input  logic [ITER_W-1:0]        maxIter,
  input  logic [TRIM_W-1:0]        dampInit,
  input  logic signed [DATA_W-1:0] winLo,
  input  logic signed [DATA_W-1:0] winHi,
  input  logic signed [DATA_W-1:0] s0In,
  input  logic signed [DATA_W-1:0] s1In,
  input  logic signed [DATA_W-1:0] s2In,
  input  logic signed [DATA_W-1:0] s3In,
  output logic [2:0]               phase,
  output logic [TRIM_W-1:0]        dampTrim,
  output logic signed [DATA_W-1:0] coilBase1,
  output logic signed [DATA_W-1:0] coilBase2,
  output logic signed [DATA_W-1:0] coilBase3,
  output logic signed [DATA_W-1:0] gndBase1,
  output logic signed [DATA_W-1:0] gndBase2,
  output logic signed [DATA_W-1:0] gndBase3,
  output logic signed [DATA_W-1:0] norm1,
  output logic signed [DATA_W-1:0] norm2,
  output logic signed [DATA_W-1:0] norm3,
  output logic                     normValid
);

  phase_e                   stateQ;
  strobe_t                  str;
  logic signed [DATA_W-1:0] sampIn [NUM_SAMP];
  logic signed [DATA_W-1:0] coilQ  [NUM_SAMP];
  logic signed [DATA_W-1:0] gndQ   [NUM_SAMP];
  logic signed [DATA_W-1:0] normQ  [NUM_SAMP];

  assign sampIn[0] = s1In;
  assign sampIn[1] = s2In;
  assign sampIn[2] = s3In;

  calib_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .ITER_W(ITER_W), .TRIM_W(TRIM_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .timingChange(timingChange), .rdyPulse(rdyPulse),
    .settleCount(settleCount), .maxIter(maxIter), .dampInit(dampInit),
    .winLo(winLo), .winHi(winHi), .s0In(s0In),
    .stateQ(stateQ), .trimQ(dampTrim), .str(str)
  );

  calib_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .str(str), .sampIn(sampIn),
    .coilQ(coilQ), .gndQ(gndQ), .normQ(normQ), .normValidQ(normValid)
  );

  assign phase     = 3'(stateQ);
  assign coilBase1 = coilQ[0];
  assign coilBase2 = coilQ[1];
  assign coilBase3 = coilQ[2];
  assign gndBase1  = gndQ[0];
  assign gndBase2  = gndQ[1];
  assign gndBase3  = gndQ[2];
  assign norm1     = normQ[0];
  assign norm2     = normQ[1];
  assign norm3     = normQ[2];

  p_norm_only_run_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) != 3'd4) |-> !normValid);

endmodule

// File: tb/test_calib_sequencer.sv
module test_calib_sequencer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic timingChange = 1'b0;
  logic rdyPulse = 1'b0;
  logic [7:0] settleCount = 8'd3;
  logic [7:0] maxIter = 8'd4;
  logic [9:0] dampInit = 10'd10;
  logic signed [15:0] winLo = 16'sd100;
  logic signed [15:0] winHi = 16'sd200;
  logic signed [15:0] s0In = '0, s1In = '0, s2In = '0, s3In = '0;
  logic [2:0] phase;
  logic [9:0] dampTrim;
  logic signed [15:0] coilBase1, coilBase2, coilBase3;
  logic signed [15:0] gndBase1, gndBase2, gndBase3;
  logic signed [15:0] norm1, norm2, norm3;
  logic normValid;

  int vecs = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  calib_sequencer i_calib_sequencer (
    .clk(clk), .rstN(rstN), .timingChange(timingChange), .rdyPulse(rdyPulse),
    .settleCount(settleCount), .maxIter(maxIter), .dampInit(dampInit),
    .winLo(winLo), .winHi(winHi), .s0In(s0In), .s1In(s1In), .s2In(s2In), .s3In(s3In),
    .phase(phase), .dampTrim(dampTrim),
    .coilBase1(coilBase1), .coilBase2(coilBase2), .coilBase3(coilBase3),
    .gndBase1(gndBase1), .gndBase2(gndBase2), .gndBase3(gndBase3),
    .norm1(norm1), .norm2(norm2), .norm3(norm3), .normValid(normValid)
  );

  task automatic check(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one ready pulse; returns just after the edge that sampled it
  task automatic pulse();
    @(negedge clk) rdyPulse = 1'b1;
    @(negedge clk) rdyPulse = 1'b0;
    #0.5;
  endtask

  task automatic restart();
    @(negedge clk) timingChange = 1'b1;
    @(negedge clk) timingChange = 1'b0;
    #0.5;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 phase in reset", int'(phase), 0);
    check("R1 normValid in reset", int'(normValid), 0);
    check("R1 coilBase1 in reset", int'(coilBase1), 0);
    check("R1 gndBase3 in reset", int'(gndBase3), 0);
    check("R1 norm2 in reset", int'(norm2), 0);
    rstN = 1'b1;
    @(negedge clk); #0.5;
    check("R1 phase after release", int'(phase), 0);
    @(negedge clk); #0.5;
    check("R4 dampTrim loaded", int'(dampTrim), 10);
  endtask

  task automatic t_calc();
    s1In = 16'sd777;
    pulse();
    pulse();
    check("R3 CALC holds after 2 pulses", int'(phase), 0);
    pulse();
    check("R3 CALC->TRIM after 3 pulses", int'(phase), 1);
    check("R10 no normValid outside RUN", int'(normValid), 0);
  endtask

  task automatic t_trim_window();
    s0In = 16'sd300; pulse();
    check("R6 trim up when high", int'(dampTrim), 11);
    check("R6 stays in TRIM", int'(phase), 1);
    s0In = 16'sd50; pulse();
    check("R6 trim down when low", int'(dampTrim), 10);
    s0In = 16'sd200; pulse();
    check("R5 in window -> COIL", int'(phase), 2);
    check("R5 trim unchanged", int'(dampTrim), 10);
  endtask

  task automatic t_coil();
    s1In = 16'sd1000; s2In = -16'sd500; s3In = 16'sd20;
    pulse(); pulse();
    check("R8 coil not yet loaded", int'(coilBase1), 0);
    check("R3 COIL holds", int'(phase), 2);
    pulse();
    check("R8 coilBase1", int'(coilBase1), 1000);
    check("R8 coilBase2", int'(coilBase2), -500);
    check("R8 coilBase3", int'(coilBase3), 20);
    check("R3 COIL->GND", int'(phase), 3);
  endtask

  task automatic t_gnd();
    s1In = 16'sd300; s2In = -16'sd200; s3In = 16'sd5;
    pulse(); pulse(); pulse();
    check("R8 gndBase1", int'(gndBase1), 300);
    check("R8 gndBase2", int'(gndBase2), -200);
    check("R8 gndBase3", int'(gndBase3), 5);
    check("R8 coil held", int'(coilBase1), 1000);
    check("R3 GND->RUN", int'(phase), 4);
  endtask

  task automatic t_run();
    s1In = 16'sd500; s2In = 16'sd32767; s3In = -16'sd32768;
    pulse();
    check("R9 norm1 difference", int'(norm1), 200);
    check("R9 norm2 positive saturation", int'(norm2), 32767);
    check("R9 norm3 negative saturation", int'(norm3), -32768);
    check("R9 normValid high", int'(normValid), 1);
    @(negedge clk); #0.5;
    check("R9 normValid one cycle", int'(normValid), 0);
    s1In = -16'sd100; s2In = -16'sd300; s3In = 16'sd5;
    pulse();
    check("R9 norm1 negative", int'(norm1), -400);
    check("R9 norm2 small", int'(norm2), -100);
    check("R9 norm3 zero", int'(norm3), 0);
  endtask

  task automatic t_restart_priority();
    restart();
    check("R11 RUN -> CALC", int'(phase), 0);
    check("R8 gnd kept across restart", int'(gndBase1), 300);
    pulse(); pulse(); pulse();
    check("R2 CALC->TRIM again", int'(phase), 1);
    // restart together with an in-window pulse
    s0In = 16'sd150;
    @(negedge clk) begin rdyPulse = 1'b1; timingChange = 1'b1; end
    @(negedge clk) begin rdyPulse = 1'b0; timingChange = 1'b0; end
    #0.5;
    check("R11 restart beats ready", int'(phase), 0);
  endtask

  task automatic t_max_iter();
    pulse(); pulse(); pulse();
    check("R3 reached TRIM", int'(phase), 1);
    s0In = 16'sd300;
    pulse(); pulse(); pulse();
    check("R7 still TRIM after 3", int'(phase), 1);
    check("R6 trim after 3 ups", int'(dampTrim), 13);
    pulse();
    check("R7 limit -> COIL", int'(phase), 2);
    check("R7 last step applied", int'(dampTrim), 14);
  endtask

  task automatic t_trim_bounds();
    dampInit = 10'd1023;
    restart();
    settleCount = 8'd0;
    pulse();
    check("R3 settleCount 0 acts as 1", int'(phase), 1);
    check("R4 dampTrim reload", int'(dampTrim), 1023);
    s0In = 16'sd300; pulse();
    check("R6 hold at max", int'(dampTrim), 1023);
    dampInit = 10'd0;
    restart();
    pulse();
    s0In = -16'sd5; pulse();
    check("R6 hold at zero", int'(dampTrim), 0);
  endtask

  initial begin
    t_reset();
    t_calc();
    t_trim_window();
    t_coil();
    t_gnd();
    t_run();
    t_restart_priority();
    t_max_iter();
    t_trim_bounds();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #100000;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule